// File: doc/BRIEF.md
# Dual-Protocol Host Register Port

This block sits between an external microprocessor bus and the core of a display controller. A static strap input selects the bus protocol. In the first protocol the host uses separate active-low read and write strobes. In the second it uses an active-high enable clock together with a read/write direction level. The chip-select line, one address bit and the strobes are brought into the core clock domain. The block then classifies each host access as one of four kinds: a status read, a data read, a data-or-parameter write, or a command write.

For each access the core receives one single-cycle pulse. For a write, the byte the host placed on the bus is held in a register. That byte is valid in the same cycle as the pulse and stays unchanged until the next completed write. For a read, the block drives either the status byte or the read-data byte supplied by the core, and raises a tristate enable for the bus pads while the read lasts.

Access handling is a four-state machine:
- `ST_IDLE` is the waiting state.
- `ST_READ` holds while a read is active.
- `ST_WRITE` holds while a write is active and keeps sampling the bus.
- `ST_BLOCK` holds after an illegal strobe combination, until every strobe is released.

The transitions are:
- IDLE→READ issues the read pulse.
- IDLE→WRITE starts capturing the bus.
- IDLE→BLOCK is taken when both strobes are asserted together.
- READ→IDLE is taken when the read ends.
- WRITE→IDLE commits the byte and issues the write pulse.
- WRITE→BLOCK abandons a write that turns into a clash.
- BLOCK→IDLE is taken once the bus is quiet.

Top module: `hostbus_port`

## Requirements
- R1: While `rst_n` is low, every pulse output, `db_oe`, `wr_byte` and `wr_a0` are 0. The machine is idle once reset is released.
- R2: While `cs_n` is 1, no pulse is issued and `db_oe` stays 0, whatever the strobes do.
- R3: With `bus_mode` = 0, asserting `cs_n`=0 and `rd_e`=0 (with `wr_rw`=1) starts a read. The read produces exactly one pulse: `stat_rd` if `a0`=0, or `data_rd` if `a0`=1. During the read `db_oe`=1, and `db_out` carries `core_status` (`a0`=0) or `core_rdata` (`a0`=1).
- R4: With `bus_mode` = 0, asserting `cs_n`=0 and `wr_rw`=0 (with `rd_e`=1) is a write. Only after the strobe returns high does the block issue exactly one single-cycle pulse: `data_wr` if `a0`=0, or `cmd_wr` if `a0`=1.
- R5: With `bus_mode` = 1, a read is `cs_n`=0 with `rd_e`=1 and `wr_rw`=1. It gives the same single pulse and the same `db_out`/`db_oe` behaviour as R3.
- R6: With `bus_mode` = 1, a write is `cs_n`=0 with `rd_e`=1 and `wr_rw`=0. It is committed when `rd_e` falls, with the same pulse selection as R4.
- R7: With `bus_mode` = 0, having both `rd_e`=0 and `wr_rw`=0 under chip select is no transaction. No pulse is issued and `db_oe` stays 0.
- R8: On a write pulse, `wr_byte` equals the bus byte and `wr_a0` equals the address bit of that write. Both hold their values until the next write pulse.
- R9: At most one of the four pulse outputs is high in any cycle, and no pulse lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bus_mode | input | 1 | Protocol strap: 0 = separate strobes, 1 = enable clock plus direction |
| cs_n | input | 1 | Active-low chip select |
| a0 | input | 1 | Address bit choosing status/data (read) or data/command (write) |
| rd_e | input | 1 | Read strobe (mode 0, active low) or enable clock (mode 1, active high) |
| wr_rw | input | 1 | Write strobe (mode 0, active low) or direction, 1 = read (mode 1) |
| db_in | input | 8 | Byte from the host data bus |
| db_out | output | 8 | Byte driven toward the host data bus |
| db_oe | output | 1 | Tristate enable for the data bus pads |
| core_status | input | 8 | Status byte supplied by the core |
| core_rdata | input | 8 | Read-data byte supplied by the core |
| wr_byte | output | 8 | Last committed write byte |
| wr_a0 | output | 1 | Address bit of the last committed write |
| cmd_wr | output | 1 | Single-cycle command-write pulse |
| data_wr | output | 1 | Single-cycle data/parameter-write pulse |
| stat_rd | output | 1 | Single-cycle status-read pulse |
| data_rd | output | 1 | Single-cycle data-read pulse |

## Verification
The hardest situation to reach is the illegal overlap of both strobes in the separate-strobe protocol. A host working correctly never produces it, and the block must then stay silent and keep the pads undriven. The stimulus drives that overlap on purpose, both in a directed case and as one of the random access kinds. It also asserts strobes while chip select is high, and switches the protocol strap between accesses. This shows that the idle level of one protocol is never taken as an access in the other.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_BLOCK = 2'd3
    } hb_state_e;

    typedef struct packed {
        logic rd_req;
        logic wr_req;
        logic clash;
        logic busy;
    } hb_req_t;

endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int          WIDTH   = 1,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/hb_decode.sv
module hb_decode
    import hb_pkg::*;
(
    input  logic    mode_e,
    input  logic    cs_n_s,
    input  logic    rd_e_s,
    input  logic    wr_rw_s,
    output hb_req_t req
);

    logic strobe_rd;
    logic strobe_wr;
    logic enable_hi;

    always_comb begin
        strobe_rd = !cs_n_s && !rd_e_s;
        strobe_wr = !cs_n_s && !wr_rw_s;
        enable_hi = !cs_n_s && rd_e_s;
        if (mode_e) begin
            req.rd_req = enable_hi && wr_rw_s;
            req.wr_req = enable_hi && !wr_rw_s;
            req.clash  = 1'b0;
            req.busy   = enable_hi;
        end else begin
            req.rd_req = strobe_rd && !strobe_wr;
            req.wr_req = strobe_wr && !strobe_rd;
            req.clash  = strobe_rd && strobe_wr;
            req.busy   = strobe_rd || strobe_wr;
        end
    end

endmodule

// File: rtl/hb_fsm.sv
module hb_fsm
    import hb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  hb_req_t       req,
    input  logic          a0_s,
    input  logic [DW-1:0] db_s,
    output logic          cmd_wr,
    output logic          data_wr,
    output logic          stat_rd,
    output logic          data_rd,
    output logic [DW-1:0] wr_byte,
    output logic          wr_a0,
    output logic          rd_a0,
    output logic          oe
);

    hb_state_e     state_q;
    hb_state_e     state_d;
    logic [DW-1:0] shadow_q;
    logic          shadow_a0_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req.clash)       state_d = ST_BLOCK;
                else if (req.rd_req) state_d = ST_READ;
                else if (req.wr_req) state_d = ST_WRITE;
            end
            ST_READ: begin
                if (!req.rd_req)     state_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (req.clash)       state_d = ST_BLOCK;
                else if (!req.wr_req) state_d = ST_IDLE;
            end
            ST_BLOCK: begin
                if (!req.busy)       state_d = ST_IDLE;
            end
            default:                 state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_wr      <= 1'b0;
            data_wr     <= 1'b0;
            stat_rd     <= 1'b0;
            data_rd     <= 1'b0;
            wr_byte     <= '0;
            wr_a0       <= 1'b0;
            rd_a0       <= 1'b0;
            oe          <= 1'b0;
            shadow_q    <= '0;
            shadow_a0_q <= 1'b0;
        end else begin
            cmd_wr  <= 1'b0;
            data_wr <= 1'b0;
            stat_rd <= 1'b0;
            data_rd <= 1'b0;
            oe      <= (state_d == ST_READ);
            if (state_q == ST_IDLE && state_d == ST_READ) begin
                stat_rd <= !a0_s;
                data_rd <= a0_s;
                rd_a0   <= a0_s;
            end
            if (state_d == ST_WRITE) begin
                shadow_q    <= db_s;
                shadow_a0_q <= a0_s;
            end
            if (state_q == ST_WRITE && state_d == ST_IDLE) begin
                wr_byte <= shadow_q;
                wr_a0   <= shadow_a0_q;
                cmd_wr  <= shadow_a0_q;
                data_wr <= !shadow_a0_q;
            end
        end
    end

endmodule

// File: rtl/hostbus_port.sv
module hostbus_port
    import hb_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_mode,
    input  logic          cs_n,
    input  logic          a0,
    input  logic          rd_e,
    input  logic          wr_rw,
    input  logic [DW-1:0] db_in,
    output logic [DW-1:0] db_out,
    output logic          db_oe,
    input  logic [DW-1:0] core_status,
    input  logic [DW-1:0] core_rdata,
    output logic [DW-1:0] wr_byte,
    output logic          wr_a0,
    output logic          cmd_wr,
    output logic          data_wr,
    output logic          stat_rd,
    output logic          data_rd
);

    localparam int SW = DW + 4;
    localparam logic [SW-1:0] SYNC_RST = {1'b1, {(SW-1){1'b0}}};

    logic [SW-1:0] raw_vec;
    logic [SW-1:0] sync_vec;
    logic          cs_n_s;
    logic          a0_s;
    logic          rd_e_s;
    logic          wr_rw_s;
    logic [DW-1:0] db_s;
    hb_req_t       req;
    logic          rd_a0;

    assign raw_vec = {cs_n, a0, rd_e, wr_rw, db_in};

    hb_sync #(
        .WIDTH   (SW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_vec),
        .q     (sync_vec)
    );

    assign {cs_n_s, a0_s, rd_e_s, wr_rw_s, db_s} = sync_vec;

    hb_decode u_decode (
        .mode_e  (bus_mode),
        .cs_n_s  (cs_n_s),
        .rd_e_s  (rd_e_s),
        .wr_rw_s (wr_rw_s),
        .req     (req)
    );

    hb_fsm #(.DW(DW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .a0_s    (a0_s),
        .db_s    (db_s),
        .cmd_wr  (cmd_wr),
        .data_wr (data_wr),
        .stat_rd (stat_rd),
        .data_rd (data_rd),
        .wr_byte (wr_byte),
        .wr_a0   (wr_a0),
        .rd_a0   (rd_a0),
        .oe      (db_oe)
    );

    assign db_out = rd_a0 ? core_rdata : core_status;

endmodule

// File: rtl/hostbus_port_chk.sv
module hostbus_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_wr,
    input logic          data_wr,
    input logic          stat_rd,
    input logic          data_rd,
    input logic          db_oe,
    input logic [DW-1:0] wr_byte,
    input logic          wr_a0
);

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_wr, data_wr, stat_rd, data_rd})); // R9

    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !cmd_wr); // R4

    AST_DATA_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !data_wr); // R6

    AST_READ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd || data_rd) |=> !(stat_rd || data_rd)); // R9

    AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_wr || data_wr) |-> ($stable(wr_byte) && $stable(wr_a0))); // R8

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd || data_rd) |-> db_oe); // R3

    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr || data_wr) |-> !db_oe); // R7

endmodule

bind hostbus_port hostbus_port_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (cmd_wr),
    .data_wr (data_wr),
    .stat_rd (stat_rd),
    .data_rd (data_rd),
    .db_oe   (db_oe),
    .wr_byte (wr_byte),
    .wr_a0   (wr_a0)
);

// File: tb/hostbus_port_tb.sv
module hostbus_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_mode = 1'b0;
    logic       cs_n = 1'b1;
    logic       a0 = 1'b0;
    logic       rd_e = 1'b1;
    logic       wr_rw = 1'b1;
    logic [7:0] db_in = 8'h00;
    logic [7:0] core_status = 8'h00;
    logic [7:0] core_rdata = 8'h00;
    logic [7:0] db_out;
    logic       db_oe;
    logic [7:0] wr_byte;
    logic       wr_a0;
    logic       cmd_wr;
    logic       data_wr;
    logic       stat_rd;
    logic       data_rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hostbus_port dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_mode    (bus_mode),
        .cs_n        (cs_n),
        .a0          (a0),
        .rd_e        (rd_e),
        .wr_rw       (wr_rw),
        .db_in       (db_in),
        .db_out      (db_out),
        .db_oe       (db_oe),
        .core_status (core_status),
        .core_rdata  (core_rdata),
        .wr_byte     (wr_byte),
        .wr_a0       (wr_a0),
        .cmd_wr      (cmd_wr),
        .data_wr     (data_wr),
        .stat_rd     (stat_rd),
        .data_rd     (data_rd)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Access kinds: 0 read, 1 write, 2 read with cs high, 3 strobe clash, 4 write with cs high
    function automatic int exp_pulses(input int kind, input bit a);
        // encoding: cmd*1000 + data_wr*100 + stat_rd*10 + data_rd
        case (kind)
            0:       return a ? 1 : 10;
            1:       return a ? 1000 : 100;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input int kind, input bit m);
        case (kind)
            0:       return m ? "R5" : "R3";
            1:       return m ? "R6" : "R4";
            3:       return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic set_idle(input bit m);
        cs_n = 1'b1;
        if (m) begin rd_e = 1'b0; wr_rw = 1'b1; end
        else   begin rd_e = 1'b1; wr_rw = 1'b1; end
    endtask

    task automatic do_txn(input int kind, input bit m, input bit a, input logic [7:0] d);
        int         n_cmd = 0;
        int         n_dwr = 0;
        int         n_srd = 0;
        int         n_drd = 0;
        int         code;
        logic [7:0] got_b = 8'h00;
        bit         got_a = 1'b0;
        bit         oe_mid = 1'b0;
        logic [7:0] out_mid = 8'h00;
        logic [7:0] exp_out;
        string      rq;

        @(negedge clk);
        set_idle(m);
        bus_mode = m;
        repeat (3) @(negedge clk);
        a0 = a;
        db_in = d;
        core_status = 8'($urandom);
        core_rdata = 8'($urandom);
        exp_out = a ? core_rdata : core_status;
        rq = req_of(kind, m);

        case (kind)
            0: begin cs_n = 1'b0; if (m) begin wr_rw = 1'b1; rd_e = 1'b1; end else rd_e = 1'b0; end
            1: begin cs_n = 1'b0; wr_rw = 1'b0; if (m) rd_e = 1'b1; end
            2: begin cs_n = 1'b1; if (m) begin wr_rw = 1'b1; rd_e = 1'b1; end else rd_e = 1'b0; end
            3: begin cs_n = 1'b0; rd_e = 1'b0; wr_rw = 1'b0; end
            default: begin cs_n = 1'b1; wr_rw = 1'b0; if (m) rd_e = 1'b1; end
        endcase

        for (int i = 0; i < 14; i++) begin
            if (i == 6) begin
                if (m) rd_e = 1'b0; else begin rd_e = 1'b1; wr_rw = 1'b1; end
                cs_n = 1'b1;
            end
            @(negedge clk);
            if (cmd_wr)  begin n_cmd++; got_b = wr_byte; got_a = wr_a0; end
            if (data_wr) begin n_dwr++; got_b = wr_byte; got_a = wr_a0; end
            if (stat_rd) n_srd++;
            if (data_rd) n_drd++;
            if (i == 4) begin oe_mid = db_oe; out_mid = db_out; end
        end

        code = n_cmd * 1000 + n_dwr * 100 + n_srd * 10 + n_drd;
        chk(code == exp_pulses(kind, a), rq, "pulse pattern (R9)", code, exp_pulses(kind, a));
        if (kind == 0) begin
            chk(oe_mid == 1'b1, rq, "db_oe during read", int'(oe_mid), 1);
            chk(out_mid == exp_out, rq, "db_out during read", int'(out_mid), int'(exp_out));
        end else begin
            chk(oe_mid == 1'b0, rq, "db_oe idle", int'(oe_mid), 0);
        end
        if (kind == 1) begin
            chk(got_b == d, "R8", "wr_byte at pulse", int'(got_b), int'(d));
            chk(got_a == a, "R8", "wr_a0 at pulse", int'(got_a), int'(a));
            chk(wr_byte == d, "R8", "wr_byte held", int'(wr_byte), int'(d));
        end
        chk(db_oe == 1'b0, rq, "db_oe after access", int'(db_oe), 0);
    endtask

    initial begin
        int kind;
        bit m;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        chk(db_oe == 1'b0, "R1", "db_oe in reset", int'(db_oe), 0);
        chk({cmd_wr, data_wr, stat_rd, data_rd} == 4'b0, "R1", "pulses in reset",
            int'({cmd_wr, data_wr, stat_rd, data_rd}), 0);
        chk(wr_byte == 8'h00, "R1", "wr_byte in reset", int'(wr_byte), 0);
        chk(wr_a0 == 1'b0, "R1", "wr_a0 in reset", int'(wr_a0), 0);
        rst_n = 1'b1;

        // directed corner cases
        do_txn(0, 1'b0, 1'b0, 8'h11);
        do_txn(0, 1'b0, 1'b1, 8'h22);
        do_txn(1, 1'b0, 1'b0, 8'hA5);
        do_txn(1, 1'b0, 1'b1, 8'h5A);
        do_txn(3, 1'b0, 1'b1, 8'hFF);
        do_txn(2, 1'b0, 1'b0, 8'h33);
        do_txn(0, 1'b1, 1'b0, 8'h44);
        do_txn(0, 1'b1, 1'b1, 8'h55);
        do_txn(1, 1'b1, 1'b0, 8'h00);
        do_txn(1, 1'b1, 1'b1, 8'hFF);
        do_txn(4, 1'b1, 1'b0, 8'h66);
        do_txn(4, 1'b0, 1'b1, 8'h77);

        // constrained random accesses
        for (int n = 0; n < 160; n++) begin
            m = 1'($urandom);
            kind = int'($urandom_range(0, 4));
            if (kind == 3 && m) kind = 1;
            do_txn(kind, m, 1'($urandom), 8'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule